// File: doc/BRIEF.md
# Data-Processing Result Routing and Status Control

This block sits after the ALU of a 32-bit RISC core and decides, for each data-processing operation, where its result and flags go. It can write a general register, load the program counter (register 15), update the condition flags in the current status register, or restore the whole current status register from the saved copy banked for the current processor mode. Compare and test opcodes never produce a register result but always set flags. A legacy status-restore variant of the equality test is also handled.

Each valid operation offered on a cycle is classified into one named action state, and the matching strobes appear one clock later. The states are `ST_IDLE` (no valid input), `ST_WR_REG` (register write, flags kept), `ST_WR_REG_FLAGS` (register write and flag update), `ST_FLAGS_ONLY` (test/compare), `ST_PC_LOAD` (PC load, status kept), `ST_PC_RESTORE` (PC load plus status restore), `ST_PC_REJECT` (PC load with S set in a mode with no saved status: restore suppressed, illegal-use raised), `ST_RESTORE_ONLY` (legacy restore in a mode that has a saved status) and `ST_NO_EFFECT` (legacy restore where no saved status exists). Every cycle is a transition straight from the current state to the state chosen by that cycle's input. A cycle without `in_valid` goes to `ST_IDLE`, and reset goes to `ST_IDLE` as well.

Top module: `dpwb_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rf_we`, `pc_load`, `flags_we`, `psr_restore` and `illegal_use` are all low.
- R2: For a valid operation whose opcode is not a test opcode and whose `in_rd` is not 15, `rf_we` is high one cycle later, with `rf_waddr` equal to `in_rd` and `rf_wdata` equal to `in_result`.
- R3: For such an operation, `flags_we` is high one cycle later with `flags_value` equal to `in_flags` when `in_sbit` is 1. It is low when `in_sbit` is 0, so the flags keep their old values.
- R4: For a non-test opcode with `in_rd` = 15 and `in_sbit` = 0, `pc_load` is high one cycle later with `pc_value` equal to `in_result`, and `rf_we`, `flags_we` and `psr_restore` are low.
- R5: For a non-test opcode with `in_rd` = 15 and `in_sbit` = 1 in a mode that has a saved status register, `pc_load` and `psr_restore` are high in the same cycle, one cycle later. `flags_we` is low and `restore_bank` names the bank.
- R6: For a non-test opcode with `in_rd` = 15 and `in_sbit` = 1 in User mode, System mode or any unlisted mode code, `pc_load` is still high, `psr_restore` stays low and `illegal_use` pulses high.
- R7: The test opcodes 4'b1000, 4'b1001, 4'b1010 and 4'b1011 never raise `rf_we` or `pc_load`, whatever `in_rd` is. They raise `flags_we` with `in_flags` even when `in_sbit` is 0.
- R8: With `in_legacy` = 1 and opcode 4'b1001, `psr_restore` is high (and `flags_we` low) one cycle later if the mode has a saved status register. Otherwise no strobe is raised. With any other opcode, `in_legacy` has no effect.
- R9: Saved-status bank indices are: mode 5'b10001 maps to 0, 5'b10010 to 1, 5'b10011 to 2, 5'b10111 to 3 and 5'b11011 to 4. User (5'b10000), System (5'b11111) and every other code have no saved status register.
- R10: A cycle with `in_valid` low produces no strobe and no `illegal_use` in the following cycle.
- R11: At most one of `rf_we` and `pc_load` is high, and `psr_restore` is never high together with `flags_we` or `illegal_use`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered this cycle |
| in_opcode | input | 4 | Decoded data-processing opcode |
| in_rd | input | 4 | Destination register index (15 = PC) |
| in_sbit | input | 1 | Set-flags bit of the instruction |
| in_legacy | input | 1 | Legacy status-restore variant marker |
| in_mode | input | 5 | Current processor mode code |
| in_result | input | 32 | ALU result |
| in_flags | input | 4 | ALU condition flags |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| pc_load | output | 1 | Load program counter strobe |
| pc_value | output | 32 | New program counter value |
| flags_we | output | 1 | Condition-flag update enable |
| flags_value | output | 4 | New condition flags |
| psr_restore | output | 1 | Copy saved status into current status |
| restore_bank | output | 3 | Index of the saved status bank to copy |
| illegal_use | output | 1 | PC-with-S used where no saved status exists |

## Verification
The assertions watch every cycle for the structural rules. Writes to the register file and PC loads exclude each other, test opcodes never write a destination, a clear S bit on an ordinary opcode never touches the flags, a restore never coincides with a flag update or an illegal-use pulse, and an idle cycle leaves every strobe low. The correctness of the values is shown only by the bench's sweep over every opcode, a set of destination indices, both S values, both legacy values and every listed mode plus an unlisted one. That sweep covers the bank index chosen per mode, the data carried to the register file and PC, and whether a given mode suppresses a restore.

// File: rtl/dpwb_pkg.sv
package dpwb_pkg;

    localparam int OPC_W   = 4;
    localparam int REG_W   = 4;
    localparam int MODE_W  = 5;
    localparam int DATA_W  = 32;
    localparam int FLAG_W  = 4;
    localparam int BANK_W  = 3;

    localparam logic [REG_W-1:0]  PC_INDEX  = 4'd15;
    localparam logic [OPC_W-1:0]  OPC_TEQ   = 4'b1001;

    localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ  = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ  = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC  = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT  = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND  = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS  = 5'b11111;

    localparam logic [BANK_W-1:0] BANK_NONE = 3'd7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_REG,
        ST_WR_REG_FLAGS,
        ST_FLAGS_ONLY,
        ST_PC_LOAD,
        ST_PC_RESTORE,
        ST_PC_REJECT,
        ST_RESTORE_ONLY,
        ST_NO_EFFECT
    } wb_state_e;

    function automatic logic is_test_op(input logic [OPC_W-1:0] op);
        return op[3:2] == 2'b10;
    endfunction

endpackage

// File: rtl/dpwb_bank_sel.sv
module dpwb_bank_sel
    import dpwb_pkg::*;
#(
    parameter int MW = MODE_W,
    parameter int BW = BANK_W
) (
    input  logic [MW-1:0] mode,
    output logic [BW-1:0] bank_idx,
    output logic          bank_ok
);

    always_comb begin
        bank_ok  = 1'b1;
        bank_idx = '0;
        unique case (mode)
            MODE_FIQ: bank_idx = BW'(0);
            MODE_IRQ: bank_idx = BW'(1);
            MODE_SVC: bank_idx = BW'(2);
            MODE_ABT: bank_idx = BW'(3);
            MODE_UND: bank_idx = BW'(4);
            default: begin
                // user, system and unlisted codes carry no saved status
                bank_ok  = 1'b0;
                bank_idx = BANK_NONE;
            end
        endcase
    end

endmodule

// File: rtl/dpwb_classify.sv
module dpwb_classify
    import dpwb_pkg::*;
#(
    parameter int OW = OPC_W,
    parameter int RW = REG_W
) (
    input  logic          valid,
    input  logic [OW-1:0] opcode,
    input  logic [RW-1:0] rd,
    input  logic          sbit,
    input  logic          legacy,
    input  logic          bank_ok,
    output wb_state_e     next_state
);

    logic test_op;
    logic to_pc;
    logic legacy_form;

    assign test_op     = is_test_op(opcode);
    assign to_pc       = (rd == PC_INDEX);
    assign legacy_form = legacy && (opcode == OPC_TEQ);

    always_comb begin
        next_state = ST_IDLE;
        if (!valid) begin
            next_state = ST_IDLE;
        end else if (test_op) begin
            if (legacy_form)
                next_state = bank_ok ? ST_RESTORE_ONLY : ST_NO_EFFECT;
            else
                next_state = ST_FLAGS_ONLY;
        end else if (to_pc) begin
            if (!sbit)
                next_state = ST_PC_LOAD;
            else
                next_state = bank_ok ? ST_PC_RESTORE : ST_PC_REJECT;
        end else begin
            next_state = sbit ? ST_WR_REG_FLAGS : ST_WR_REG;
        end
    end

endmodule

// File: rtl/dpwb_ctrl.sv
module dpwb_ctrl
    import dpwb_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  in_opcode,
    input  logic [REG_W-1:0]  in_rd,
    input  logic              in_sbit,
    input  logic              in_legacy,
    input  logic [MODE_W-1:0] in_mode,
    input  logic [DW-1:0]     in_result,
    input  logic [FW-1:0]     in_flags,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [DW-1:0]     rf_wdata,
    output logic              pc_load,
    output logic [DW-1:0]     pc_value,
    output logic              flags_we,
    output logic [FW-1:0]     flags_value,
    output logic              psr_restore,
    output logic [BANK_W-1:0] restore_bank,
    output logic              illegal_use
);

    wb_state_e          state_q;
    wb_state_e          state_d;
    logic [BANK_W-1:0]  bank_idx;
    logic               bank_ok;
    logic [REG_W-1:0]   rd_q;
    logic [DW-1:0]      result_q;
    logic [FW-1:0]      flags_q;
    logic [BANK_W-1:0]  bank_q;

    dpwb_bank_sel #(.MW(MODE_W), .BW(BANK_W)) u_bank (
        .mode     (in_mode),
        .bank_idx (bank_idx),
        .bank_ok  (bank_ok)
    );

    dpwb_classify #(.OW(OPC_W), .RW(REG_W)) u_class (
        .valid      (in_valid),
        .opcode     (in_opcode),
        .rd         (in_rd),
        .sbit       (in_sbit),
        .legacy     (in_legacy),
        .bank_ok    (bank_ok),
        .next_state (state_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q     <= '0;
            result_q <= '0;
            flags_q  <= '0;
            bank_q   <= BANK_NONE;
        end else if (in_valid) begin
            rd_q     <= in_rd;
            result_q <= in_result;
            flags_q  <= in_flags;
            bank_q   <= bank_idx;
        end
    end

    assign rf_waddr     = rd_q;
    assign rf_wdata     = result_q;
    assign pc_value     = result_q;
    assign flags_value  = flags_q;
    assign restore_bank = bank_q;

    // output decode
    always_comb begin
        rf_we       = 1'b0;
        pc_load     = 1'b0;
        flags_we    = 1'b0;
        psr_restore = 1'b0;
        illegal_use = 1'b0;
        unique case (state_q)
            ST_IDLE:         ;
            ST_WR_REG:       rf_we = 1'b1;
            ST_WR_REG_FLAGS: begin rf_we = 1'b1; flags_we = 1'b1; end
            ST_FLAGS_ONLY:   flags_we = 1'b1;
            ST_PC_LOAD:      pc_load = 1'b1;
            ST_PC_RESTORE:   begin pc_load = 1'b1; psr_restore = 1'b1; end
            ST_PC_REJECT:    begin pc_load = 1'b1; illegal_use = 1'b1; end
            ST_RESTORE_ONLY: psr_restore = 1'b1;
            ST_NO_EFFECT:    ;
            default:         ;
        endcase
    end

endmodule

// File: rtl/dpwb_ctrl_chk.sv
module dpwb_ctrl_chk
    import dpwb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OPC_W-1:0]  in_opcode,
    input logic [REG_W-1:0]  in_rd,
    input logic              in_sbit,
    input logic              rf_we,
    input logic              pc_load,
    input logic              flags_we,
    input logic              psr_restore,
    input logic              illegal_use
);

    logic ordinary_q;
    logic test_q;
    logic ord_to_pc_q;
    logic ord_no_s_q;
    logic idle_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ordinary_q  <= 1'b0;
            test_q      <= 1'b0;
            ord_to_pc_q <= 1'b0;
            ord_no_s_q  <= 1'b0;
            idle_q      <= 1'b1;
        end else begin
            test_q      <= in_valid && is_test_op(in_opcode);
            ordinary_q  <= in_valid && !is_test_op(in_opcode) && in_rd != PC_INDEX;
            ord_to_pc_q <= in_valid && !is_test_op(in_opcode) && in_rd == PC_INDEX;
            ord_no_s_q  <= in_valid && !is_test_op(in_opcode) && !in_sbit;
            idle_q      <= !in_valid;
        end
    end

    assert_excl_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && pc_load));

    assert_restore_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
        psr_restore |-> !flags_we && !illegal_use);

    assert_test_no_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        test_q |-> !rf_we && !pc_load && !illegal_use);

    assert_reg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ordinary_q |-> rf_we && !pc_load);

    assert_pc_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ord_to_pc_q |-> pc_load && !rf_we && !flags_we);

    assert_flags_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ord_no_s_q |-> !flags_we && !psr_restore);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q |-> !rf_we && !pc_load && !flags_we && !psr_restore && !illegal_use);

    assert_illegal_has_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_use |-> pc_load);

endmodule

bind dpwb_ctrl dpwb_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_opcode   (in_opcode),
    .in_rd       (in_rd),
    .in_sbit     (in_sbit),
    .rf_we       (rf_we),
    .pc_load     (pc_load),
    .flags_we    (flags_we),
    .psr_restore (psr_restore),
    .illegal_use (illegal_use)
);

// File: tb/dpwb_ctrl_test.sv
module dpwb_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_opcode = '0;
    logic [3:0]  in_rd = '0;
    logic        in_sbit = 1'b0;
    logic        in_legacy = 1'b0;
    logic [4:0]  in_mode = 5'b10000;
    logic [31:0] in_result = '0;
    logic [3:0]  in_flags = '0;
    logic        rf_we, pc_load, flags_we, psr_restore, illegal_use;
    logic [3:0]  rf_waddr, flags_value;
    logic [31:0] rf_wdata, pc_value;
    logic [2:0]  restore_bank;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dpwb_ctrl uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_rd(in_rd), .in_sbit(in_sbit), .in_legacy(in_legacy), .in_mode(in_mode),
        .in_result(in_result), .in_flags(in_flags), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .pc_load(pc_load), .pc_value(pc_value), .flags_we(flags_we),
        .flags_value(flags_value), .psr_restore(psr_restore), .restore_bank(restore_bank),
        .illegal_use(illegal_use)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_strobes(input string req, input logic [4:0] exp);
        check(req, "strobes{rf,pc,fl,rs,il}", {27'd0, rf_we, pc_load, flags_we, psr_restore, illegal_use}, {27'd0, exp});
    endtask

    // R9 mode list for the sweep, including one unlisted code
    function automatic logic [4:0] mode_at(input int i);
        case (i)
            0: return 5'b10000; 1: return 5'b10001; 2: return 5'b10010; 3: return 5'b10011;
            4: return 5'b10111; 5: return 5'b11011; 6: return 5'b11111; default: return 5'b00110;
        endcase
    endfunction

    function automatic int bank_of(input logic [4:0] m);
        case (m)
            5'b10001: return 0; 5'b10010: return 1; 5'b10011: return 2;
            5'b10111: return 3; 5'b11011: return 4; default: return -1;
        endcase
    endfunction

    initial begin
        #400000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: strobes low during and just after reset
        repeat (3) @(negedge clk);
        check_strobes("R1", 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_strobes("R1", 5'b00000);

        for (int op = 0; op < 16; op++) begin
            for (int ri = 0; ri < 4; ri++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int lg = 0; lg < 2; lg++) begin
                        for (int mi = 0; mi < 8; mi++) begin
                            logic [3:0] rd;
                            logic [31:0] res;
                            logic [3:0] fl;
                            logic [4:0] exp;
                            string req;
                            int bk;
                            bit test;
                            rd  = (ri == 3) ? 4'd15 : 4'(ri * 7);
                            res = 32'h9E37_79B9 * (op * 64 + ri * 16 + s * 8 + lg * 4 + mi + 1);
                            fl  = 4'(op + mi + s);
                            bk  = bank_of(mode_at(mi));
                            test = (op >= 8 && op <= 11);
                            in_valid = 1'b1; in_opcode = 4'(op); in_rd = rd;
                            in_sbit = 1'(s); in_legacy = 1'(lg); in_mode = mode_at(mi);
                            in_result = res; in_flags = fl;
                            if (test && lg == 1 && op == 9) begin
                                req = "R8";
                                exp = (bk >= 0) ? 5'b00010 : 5'b00000;
                            end else if (test) begin
                                req = "R7"; exp = 5'b00100;
                            end else if (rd == 4'd15) begin
                                if (s == 0) begin req = "R4"; exp = 5'b01000; end
                                else if (bk >= 0) begin req = "R5"; exp = 5'b01010; end
                                else begin req = "R6"; exp = 5'b01001; end
                            end else begin
                                req = (s == 1) ? "R3" : "R2";
                                exp = (s == 1) ? 5'b10100 : 5'b10000;
                            end
                            @(negedge clk);
                            check_strobes(req, exp);
                            if (exp[4]) begin
                                check("R2", "rf_waddr", {28'd0, rf_waddr}, {28'd0, rd});
                                check("R2", "rf_wdata", rf_wdata, res);
                            end
                            if (exp[3]) check(req, "pc_value", pc_value, res);
                            if (exp[2]) check(req, "flags_value", {28'd0, flags_value}, {28'd0, fl});
                            if (exp[1]) check("R9", "restore_bank", {29'd0, restore_bank}, 32'(bk));
                            if (exp[4] && exp[3]) check("R11", "rf_we with pc_load", 1, 0);
                        end
                    end
                end
            end
            // R10: an idle cycle between opcode groups
            in_valid = 1'b0;
            in_opcode = 4'd0; in_rd = 4'd15; in_sbit = 1'b1; in_mode = 5'b10000;
            @(negedge clk);
            check_strobes("R10", 5'b00000);
        end

        // R1: reset in the middle of traffic clears outputs
        in_valid = 1'b1; in_opcode = 4'd4; in_rd = 4'd3; in_sbit = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check_strobes("R1", 5'b00000);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_strobes("R1", 5'b00000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule